// File: doc/BRIEF.md
# FPGA Serial Configuration Sequencer

This block loads a configuration image into an SRAM-based FPGA through the target's serial slave configuration port. It owns four outputs toward the target: an active-low reset, an active-low chip select, a serial clock and a serial data line. It watches the target's done flag. Image bytes come in on a valid/ready byte stream. The total byte count is latched from `len_i` when a one-cycle `start_i` pulse launches a load.

All delays are counted in system clock cycles and derived from the `CLK_HZ` parameter:
- the reset hold of `RESET_NS` nanoseconds;
- the initialisation pause of `INIT_US` microseconds;
- the serial clock half-period, which is `ceil(CLK_HZ / (2*SCLK_HZ))` cycles.

The serial clock idles high. The target samples data on rising edges, and the data line moves only on falling edges.

The sequence is driven by one state machine. Its states and transitions are:
- `ST_IDLE` goes to `ST_RST_LOW` on `start_i`.
- `ST_RST_LOW` lasts one cycle with reset low and chip select high, then goes to `ST_CS_SETUP`.
- `ST_CS_SETUP` holds reset low with chip select low for the reset hold time, then goes to `ST_INIT_WAIT`.
- `ST_INIT_WAIT` releases reset, keeps chip select low and issues no clocks for the initialisation pause, then goes to `ST_DUMMY`.
- `ST_DUMMY` raises chip select and issues the dummy clocks, then goes to `ST_STREAM`.
- `ST_STREAM` lowers chip select and shifts every byte out, then goes to `ST_AWAIT_DONE`.
- `ST_AWAIT_DONE` keeps clocking until the synchronised done flag is high. It goes to `ST_TRAIL` on done, or back to `ST_IDLE` with the error flag set on timeout.
- `ST_TRAIL` sends the trailing clocks and returns to `ST_IDLE` with the success flag set.

Top module: `fpga_cfg_loader`

## Requirements
- R1: After `start_i`, `creset_n_o` goes low while `cs_n_o` is still high. Then `cs_n_o` goes low. Reset stays low with chip select low for at least `ceil(RESET_NS*CLK_HZ/1e9)` cycles. Reset is only ever released while chip select is low.
- R2: After reset is released, chip select stays low and no serial clock edge occurs for at least `ceil(INIT_US*CLK_HZ/1e6)` cycles.
- R3: Exactly `DUMMY_CLKS` (default 8) rising serial clock edges occur while `cs_n_o` is high. Then `cs_n_o` goes low for the data.
- R4: `sclk_o` is high whenever the block is idle. Each high and each low phase lasts at least `ceil(CLK_HZ/(2*SCLK_HZ))` cycles, so the shortest rise-to-rise period is twice that.
- R5: Each byte is sent most significant bit first, bit 7 down to bit 0, one bit per rising edge. `mosi_o` changes only in the cycle where `sclk_o` falls.
- R6: A byte is taken when `byte_valid_i` and `byte_ready_o` are both high. `byte_ready_o` is high only during a load, and only while bytes remain. Exactly `len_i` bytes are taken. While no byte is available, the clock holds high.
- R7: The done input passes through two flip-flops. Once it is seen high, at least `POST_DONE_CLKS + USER_IO_CLKS` (100 + 49) further rising edges are sent with chip select low. Then `cs_n_o` goes high and `done_ok_o` is set.
- R8: If done is not seen within `DONE_TIMEOUT_CLKS` rising edges after the last data bit, the load stops after exactly that many edges. `cs_n_o` goes high and `err_o` is set. `err_o` stays set until the next start.
- R9: `busy_o` is high from the cycle after an accepted start until the return to idle. An accepted start clears both flags. `err_o` and `done_ok_o` are never high together.
- R10: A `start_i` pulse during a load has no effect: there is only one reset pulse, and the image is delivered unchanged.
- R11: After system reset the outputs are as follows: `creset_n_o`=1, `cs_n_o`=1, `sclk_o`=1, `mosi_o`=1, and `busy_o`, `done_ok_o`, `err_o`, `byte_ready_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches a load |
| len_i | input | LEN_W | Image length in bytes, latched at start |
| byte_data_i | input | 8 | Image byte |
| byte_valid_i | input | 1 | Image byte is valid |
| byte_ready_o | output | 1 | Block accepts an image byte |
| cdone_i | input | 1 | Target done flag, asynchronous |
| creset_n_o | output | 1 | Target reset, active low |
| cs_n_o | output | 1 | Target chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial data to the target |
| busy_o | output | 1 | A load is in progress |
| done_ok_o | output | 1 | Last load completed, sticky until next start |
| err_o | output | 1 | Last load timed out waiting for done, sticky until next start |

## Verification
The hardest situations to reach from the ports are two. One is a byte stream stall that lands exactly on a byte boundary. The other is the done flag rising at an arbitrary point in the post-data clocking, close to the two-flop delay.

The bench builds a target model that decodes the serial pins. The model raises done after a randomly chosen number of post-data clocks. It never raises done in one load, which forces the timeout. The byte source drops valid at random, which creates boundary stalls. A stray start is injected partway through one load to show that it is ignored.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_CS_SETUP,
        ST_INIT_WAIT,
        ST_DUMMY,
        ST_STREAM,
        ST_AWAIT_DONE,
        ST_TRAIL
    } load_state_e;

    // Rounded-up integer division, always at least one.
    function automatic int unsigned ceil_div(longint unsigned num, longint unsigned den);
        longint unsigned q;
        q = (num + den - 64'd1) / den;
        if (q == 64'd0) begin
            q = 64'd1;
        end
        return int'(q);
    endfunction

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_q) |-> $past(meta_q));

endmodule

// File: rtl/cfg_sclk_gen.sv
module cfg_sclk_gen #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic sclk_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int unsigned CW = $clog2(HALF_DIV) + 1;

    logic [CW-1:0] cnt_q;
    logic          sclk_q;
    logic          cnt_done;

    assign cnt_done = (cnt_q == CW'(HALF_DIV - 1));
    assign fall_o   = run_i && sclk_q && cnt_done;
    assign rise_o   = !sclk_q && cnt_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else begin
            if (fall_o || rise_o) begin
                cnt_q <= '0;
            end else if (!cnt_done) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (fall_o) begin
                sclk_q <= 1'b0;
            end else if (rise_o) begin
                sclk_q <= 1'b1;
            end
        end
    end

    assign sclk_o = sclk_q;

    // R4
    fall_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_q) |-> $past(run_i));

    // R4
    low_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_q) |-> $past(cnt_q) == CW'(HALF_DIV - 1));

endmodule

// File: rtl/cfg_byte_shifter.sv
module cfg_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear_i,
    input  logic       enable_i,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    output logic       ready_o,
    input  logic       shift_i,
    output logic       need_o,
    output logic       idle_o,
    output logic       mosi_o
);
    logic [7:0] hold_q;
    logic       have_q;
    logic [7:0] sh_q;
    logic [2:0] bits_left_q;
    logic       mosi_q;

    assign ready_o = enable_i && !have_q;
    assign need_o  = have_q || (bits_left_q != 3'd0);
    assign idle_o  = !have_q && (bits_left_q == 3'd0);
    assign mosi_o  = mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            have_q      <= 1'b0;
            sh_q        <= '0;
            bits_left_q <= '0;
            mosi_q      <= 1'b1;
        end else if (clear_i) begin
            have_q      <= 1'b0;
            bits_left_q <= '0;
        end else begin
            if (valid_i && ready_o) begin
                hold_q <= data_i;
                have_q <= 1'b1;
            end
            if (shift_i) begin
                if (bits_left_q == 3'd0) begin
                    mosi_q      <= hold_q[7];
                    sh_q        <= {hold_q[6:0], 1'b0};
                    bits_left_q <= 3'd7;
                    have_q      <= 1'b0;
                end else begin
                    mosi_q      <= sh_q[7];
                    sh_q        <= {sh_q[6:0], 1'b0};
                    bits_left_q <= bits_left_q - 3'd1;
                end
            end
        end
    end

    // R5
    shift_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |-> (have_q || bits_left_q != 3'd0));

    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |-> !have_q);

endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned CLK_HZ            = 50_000_000,
    parameter int unsigned SCLK_HZ           = 12_500_000,
    parameter int unsigned RESET_NS          = 200,
    parameter int unsigned INIT_US           = 1200,
    parameter int unsigned DUMMY_CLKS        = 8,
    parameter int unsigned POST_DONE_CLKS    = 100,
    parameter int unsigned USER_IO_CLKS      = 49,
    parameter int unsigned DONE_TIMEOUT_CLKS = 4096,
    parameter int unsigned LEN_W             = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    input  logic             cdone_i,
    output logic             creset_n_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic             done_ok_o,
    output logic             err_o
);
    localparam int unsigned HALF_DIV   = ceil_div(64'(CLK_HZ), 64'(2) * 64'(SCLK_HZ));
    localparam int unsigned RST_CYC    = ceil_div(64'(RESET_NS) * 64'(CLK_HZ), 64'd1_000_000_000);
    localparam int unsigned INIT_CYC   = ceil_div(64'(INIT_US) * 64'(CLK_HZ), 64'd1_000_000);
    localparam int unsigned TRAIL_CLKS = POST_DONE_CLKS + USER_IO_CLKS;
    localparam int unsigned CMAX_A     = (TRAIL_CLKS > DUMMY_CLKS) ? TRAIL_CLKS : DUMMY_CLKS;
    localparam int unsigned CLK_MAX    = (DONE_TIMEOUT_CLKS > CMAX_A) ? DONE_TIMEOUT_CLKS : CMAX_A;
    localparam int unsigned WAIT_MAX   = (INIT_CYC > RST_CYC) ? INIT_CYC : RST_CYC;
    localparam int unsigned CCNT_W     = $clog2(CLK_MAX + 1);
    localparam int unsigned WCNT_W     = $clog2(WAIT_MAX + 1);

    load_state_e       state_q, state_d;
    logic [WCNT_W-1:0] wcnt_q;
    logic [CCNT_W-1:0] ccnt_q;
    logic [LEN_W-1:0]  rem_q;
    logic              err_q, ok_q;

    logic done_s;
    logic run, fall, rise;
    logic sh_need, sh_idle, sh_enable, sh_clear, accept;
    logic start_ok;
    logic wait_over, dummy_over, trail_over, timeout_hit;

    cfg_sync2 u_done_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (cdone_i),
        .q_o   (done_s)
    );

    cfg_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .sclk_o (sclk_o),
        .fall_o (fall),
        .rise_o (rise)
    );

    assign sh_enable = (state_q == ST_STREAM) && (rem_q != '0);
    assign sh_clear  = start_ok;

    cfg_byte_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (sh_clear),
        .enable_i (sh_enable),
        .data_i   (byte_data_i),
        .valid_i  (byte_valid_i),
        .ready_o  (byte_ready_o),
        .shift_i  (fall && (state_q == ST_STREAM)),
        .need_o   (sh_need),
        .idle_o   (sh_idle),
        .mosi_o   (mosi_o)
    );

    assign accept      = byte_valid_i && byte_ready_o;
    assign start_ok    = (state_q == ST_IDLE) && start_i;
    assign dummy_over  = (ccnt_q == CCNT_W'(DUMMY_CLKS));
    assign trail_over  = (ccnt_q == CCNT_W'(TRAIL_CLKS));
    assign timeout_hit = (ccnt_q == CCNT_W'(DONE_TIMEOUT_CLKS));

    always_comb begin
        wait_over = 1'b0;
        if (state_q == ST_CS_SETUP) begin
            wait_over = (wcnt_q == WCNT_W'(RST_CYC - 1));
        end else if (state_q == ST_INIT_WAIT) begin
            wait_over = (wcnt_q == WCNT_W'(INIT_CYC - 1));
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_RST_LOW;
            ST_RST_LOW:    state_d = ST_CS_SETUP;
            ST_CS_SETUP:   if (wait_over) state_d = ST_INIT_WAIT;
            ST_INIT_WAIT:  if (wait_over) state_d = ST_DUMMY;
            ST_DUMMY:      if (dummy_over) state_d = ST_STREAM;
            ST_STREAM:     if (rem_q == '0 && sh_idle && sclk_o) state_d = ST_AWAIT_DONE;
            ST_AWAIT_DONE: begin
                if (done_s && sclk_o) begin
                    state_d = ST_TRAIL;
                end else if (timeout_hit) begin
                    state_d = ST_IDLE;
                end
            end
            ST_TRAIL:      if (trail_over) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Counters, remaining length and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            ccnt_q <= '0;
            rem_q  <= '0;
            err_q  <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                wcnt_q <= '0;
                ccnt_q <= '0;
            end else begin
                wcnt_q <= wcnt_q + 1'b1;
                if (rise) begin
                    ccnt_q <= ccnt_q + 1'b1;
                end
            end
            if (start_ok) begin
                rem_q <= len_i;
                err_q <= 1'b0;
                ok_q  <= 1'b0;
            end else if (accept) begin
                rem_q <= rem_q - 1'b1;
            end
            if (state_q == ST_AWAIT_DONE && state_d == ST_IDLE) begin
                err_q <= 1'b1;
            end
            if (state_q == ST_TRAIL && state_d == ST_IDLE) begin
                ok_q <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        creset_n_o = 1'b1;
        cs_n_o     = 1'b1;
        run        = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_RST_LOW:    creset_n_o = 1'b0;
            ST_CS_SETUP: begin
                creset_n_o = 1'b0;
                cs_n_o     = 1'b0;
            end
            ST_INIT_WAIT:  cs_n_o = 1'b0;
            ST_DUMMY:      run = !dummy_over;
            ST_STREAM: begin
                cs_n_o = 1'b0;
                run    = sh_need;
            end
            ST_AWAIT_DONE: begin
                cs_n_o = 1'b0;
                run    = !timeout_hit;
            end
            ST_TRAIL: begin
                cs_n_o = 1'b0;
                run    = !trail_over;
            end
            default:       ;
        endcase
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_ok_o = ok_q;
    assign err_o     = err_q;

    // R1
    creset_rise_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(creset_n_o) |-> !cs_n_o);

    // R4
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> sclk_o);

    // R5
    mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_o) |-> $fell(sclk_o));

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && done_ok_o));

    // R6
    ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> busy_o);

    // R2
    no_clock_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INIT_WAIT) |-> sclk_o);

endmodule

// File: tb/fpga_cfg_loader_bench.sv
`timescale 1ns/1ps
module fpga_cfg_loader_bench;
    localparam int CLK_PERIOD = 100;
    localparam int unsigned P_CLK_HZ  = 10_000_000;
    localparam int unsigned P_SCLK_HZ = 2_500_000;
    localparam int unsigned P_RST_NS  = 200;
    localparam int unsigned P_INIT_US = 20;
    localparam int unsigned P_DUMMY   = 8;
    localparam int unsigned P_POST    = 100;
    localparam int unsigned P_USERIO  = 49;
    localparam int unsigned P_TO      = 40;
    localparam int unsigned P_LEN_W   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [P_LEN_W-1:0] len_i = '0;
    logic [7:0] byte_data_i = '0;
    logic byte_valid_i = 1'b0;
    logic byte_ready_o, creset_n_o, cs_n_o, sclk_o, mosi_o, busy_o, done_ok_o, err_o;
    logic cdone_m = 1'b0;

    fpga_cfg_loader #(
        .CLK_HZ(P_CLK_HZ), .SCLK_HZ(P_SCLK_HZ), .RESET_NS(P_RST_NS), .INIT_US(P_INIT_US),
        .DUMMY_CLKS(P_DUMMY), .POST_DONE_CLKS(P_POST), .USER_IO_CLKS(P_USERIO),
        .DONE_TIMEOUT_CLKS(P_TO), .LEN_W(P_LEN_W)
    ) u_fpga_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
        .cdone_i(cdone_m), .creset_n_o(creset_n_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .busy_o(busy_o), .done_ok_o(done_ok_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;

    function automatic int exp_half();
        return int'((64'(P_CLK_HZ) + 64'(2*P_SCLK_HZ) - 1) / 64'(2*P_SCLK_HZ));
    endfunction
    function automatic int exp_rst();
        return int'((64'(P_RST_NS) * 64'(P_CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction
    function automatic int exp_init();
        return int'((64'(P_INIT_US) * 64'(P_CLK_HZ) + 64'd999_999) / 64'd1_000_000);
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Target model state, all owned by the monitor below
    logic [7:0] img [0:63];
    logic [7:0] rx [0:63];
    int exp_len = 0;
    int done_delay = -1;
    int bitn, wait_cnt, trail_cnt, dummy_cnt, rst_cnt, init_cnt, accepted, creset_falls;
    int min_per, since_rise;
    bit had_rise, clocked, cs_seen, cs_fell_creset;
    logic [7:0] rx_sh;
    logic prev_sclk = 1'b1, prev_cs = 1'b1, prev_creset = 1'b1, prev_busy = 1'b0;

    always @(negedge clk) begin
        if (busy_o && !prev_busy) begin
            bitn = 0; wait_cnt = 0; trail_cnt = 0; dummy_cnt = 0; rst_cnt = 0;
            init_cnt = 0; accepted = 0; creset_falls = 0; min_per = 1000;
            since_rise = 0; had_rise = 0; clocked = 0; cs_seen = 0; cs_fell_creset = 1;
            cdone_m = 1'b0;
        end
        if (prev_creset && !creset_n_o) creset_falls++;
        if (!creset_n_o && !cs_n_o) rst_cnt++;
        if (creset_n_o && !cs_n_o && busy_o && !clocked) init_cnt++;
        if (prev_cs && !cs_n_o && !cs_seen) begin
            cs_seen = 1;
            cs_fell_creset = creset_n_o;
        end
        if (byte_valid_i && byte_ready_o) accepted++;
        if (!sclk_o && prev_sclk) clocked = 1;
        since_rise++;
        if (sclk_o && !prev_sclk) begin
            if (had_rise && since_rise < min_per) min_per = since_rise;
            since_rise = 0;
            had_rise = 1;
            if (cs_n_o) begin
                dummy_cnt++;
            end else if (cdone_m) begin
                trail_cnt++;
            end else if (bitn < exp_len * 8) begin
                rx_sh = {rx_sh[6:0], mosi_o};
                bitn++;
                if (bitn % 8 == 0) rx[bitn/8 - 1] = rx_sh;
            end else begin
                wait_cnt++;
                if (done_delay > 0 && wait_cnt == done_delay) cdone_m = 1'b1;
            end
        end
        prev_sclk = sclk_o; prev_cs = cs_n_o; prev_creset = creset_n_o; prev_busy = busy_o;
    end

    task automatic feed(input int len);
        int idx = 0;
        while (idx < len) begin
            @(negedge clk);
            byte_data_i  = img[idx];
            byte_valid_i = ($urandom % 4) != 0;
            if (byte_valid_i && byte_ready_o) idx++;
        end
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    task automatic run_load(input int len, input int delay, input bit inject, input bit expect_ok);
        int guard = 0;
        int mism = 0;
        exp_len = len;
        done_delay = delay;
        @(negedge clk);
        start_i = 1'b1;
        len_i = P_LEN_W'(len);
        @(negedge clk);
        start_i = 1'b0;
        // R9: busy and flags cleared after an accepted start
        check(busy_o == 1'b1, "R9", "busy after start", int'(busy_o), 1);
        check(err_o == 1'b0 && done_ok_o == 1'b0, "R9", "flags cleared", int'(err_o) + int'(done_ok_o), 0);
        fork
            feed(len);
            begin
                if (inject) begin
                    repeat (300) @(negedge clk);
                    start_i = 1'b1;
                    @(negedge clk);
                    start_i = 1'b0;
                end
            end
        join
        while (busy_o && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(!busy_o, "R9", "load returned to idle", int'(busy_o), 0);
        check(cs_fell_creset == 1'b0, "R1", "creset low when cs fell", int'(cs_fell_creset), 0);
        check(rst_cnt >= exp_rst(), "R1", "reset hold cycles", rst_cnt, exp_rst());
        check(init_cnt >= exp_init(), "R2", "init pause cycles", init_cnt, exp_init());
        check(dummy_cnt == P_DUMMY, "R3", "dummy clocks", dummy_cnt, P_DUMMY);
        check(min_per == 2 * exp_half(), "R4", "min sclk period", min_per, 2 * exp_half());
        check(accepted == len, "R6", "bytes accepted", accepted, len);
        for (int i = 0; i < len; i++) if (rx[i] !== img[i]) mism++;
        check(mism == 0 && bitn == len * 8, "R5", "mismatched bytes", mism, 0);
        check(creset_falls == 1, inject ? "R10" : "R1", "reset pulses", creset_falls, 1);
        check(cs_n_o && sclk_o && creset_n_o, "R8", "pins idle after load", int'(cs_n_o & sclk_o & creset_n_o), 1);
        if (expect_ok) begin
            check(trail_cnt >= int'(P_POST + P_USERIO) && trail_cnt <= int'(P_POST + P_USERIO) + 3,
                  "R7", "trailing clocks", trail_cnt, P_POST + P_USERIO);
            check(done_ok_o && !err_o, "R7", "success flag", int'(done_ok_o), 1);
        end else begin
            check(wait_cnt == P_TO, "R8", "clocks before timeout", wait_cnt, P_TO);
            check(err_o && !done_ok_o, "R8", "error flag", int'(err_o), 1);
        end
    endtask

    initial begin
        repeat (20000) @(negedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c3a_5e11));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(creset_n_o && cs_n_o && sclk_o && mosi_o, "R11", "pins in reset", 
              int'({creset_n_o, cs_n_o, sclk_o, mosi_o}), 15);
        check(!busy_o && !done_ok_o && !err_o && !byte_ready_o, "R11", "status in reset",
              int'({busy_o, done_ok_o, err_o, byte_ready_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy_o && sclk_o, "R11", "idle after release", int'(busy_o), 0);

        // Single byte, done right after data
        img[0] = 8'hC3;
        run_load(1, 1, 1'b0, 1'b1);

        // Bit-order corners
        img[0] = 8'h80; img[1] = 8'h01; img[2] = 8'hA5; img[3] = 8'hFF;
        run_load(4, 3, 1'b0, 1'b1);

        // Random images and done delays
        for (int k = 0; k < 3; k++) begin
            int n = 1 + int'($urandom % 24);
            for (int i = 0; i < n; i++) img[i] = 8'($urandom);
            run_load(n, 1 + int'($urandom % 8), 1'b0, 1'b1);
        end

        // R10 stray start in the middle of a load
        for (int i = 0; i < 16; i++) img[i] = 8'($urandom);
        run_load(16, 5, 1'b1, 1'b1);

        // R8 done never rises
        for (int i = 0; i < 6; i++) img[i] = 8'($urandom);
        run_load(6, -1, 1'b0, 1'b0);
        repeat (50) @(negedge clk);
        check(err_o == 1'b1, "R8", "error stays set while idle", int'(err_o), 1);
        check(byte_ready_o == 1'b0, "R6", "no ready while idle", int'(byte_ready_o), 0);

        // Next load clears the error
        for (int i = 0; i < 3; i++) img[i] = 8'($urandom);
        run_load(3, 2, 1'b0, 1'b1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule